// File: doc/BRIEF.md
# Rank-Serial Cover Scanner

This block builds the attack (cover) map of one side on a 9x9 board, counting only the one-step moves of every piece and the knight's jump. Sliding continuations, drops, check detection and move lists are left to other units. The board is streamed in one rank per clock, with nine squares side by side in each beat. After a fixed scan phase, the finished map is streamed out one rank per clock. Two instances with different `SIDE` values give the cover maps of both players from the same board stream.

Each incoming rank is expanded through a small reach table per square. The table yields the squares that piece covers, from two ranks behind to two ranks ahead. These spilled bits are ORed into a whole-board accumulator. The scan phase lasts 11 clocks: nine data beats plus two drain beats, which cover the knight's two-rank reach. The output phase also lasts 11 clocks. Latency is therefore the same for every board, however many pieces it holds.

Top module: `rcov_scan`

## Requirements
- R1: While `rst_n` is low, and after release until the first output beat, `cov_valid` is 0 and `cov_bits` is all zero.
- R2: A square is 5 bits, and file f of `brd_rank` occupies bits [5f+4:5f]. Bit 4 is the owner (0 black, 1 white), and bits 3:0 are the piece code: 0 empty, 1 pawn, 2 lance, 3 knight, 4 silver, 5 gold, 6 bishop, 7 rook, 8 king, 9..12 promoted pawn/lance/knight/silver, 13 promoted bishop, 14 promoted rook, 15 spare. Only squares whose owner bit equals `SIDE` contribute. Codes 0 and 15 cover nothing.
- R3: Pawn and lance cover the one square straight forward. A knight covers the two squares two ranks forward and one file to either side.
- R4: A silver covers the three forward squares and the two backward diagonals. Gold and codes 9..12 cover the three forward squares, the two side squares and the square straight back.
- R5: A bishop covers its four diagonal neighbours. A rook covers its four orthogonal neighbours. King, code 13 and code 14 cover all eight neighbours.
- R6: For `SIDE`=0, forward means toward lower rank index (earlier beats). For `SIDE`=1, it means toward higher rank index.
- R7: Targets beyond the board edge are dropped, with no wrap across files or ranks. A covered square is marked whatever occupies it, and the map is the OR of all contributions.
- R8: Each accepted board gives exactly nine consecutive cycles of `cov_valid`, rank 0 first. Bit f of `cov_bits` is file f. `cov_bits` is zero whenever `cov_valid` is low.
- R9: A board is accepted on a clock edge with `brd_start` and `brd_valid` high while idle. That beat is rank 0, and ranks 1..8 follow on the next eight edges. `cov_valid` is first set by the 11th edge after the accepting edge, whatever the board content.
- R10: After accepting, the block is busy for 22 edges (11 scan, 11 output). A `brd_start` on any edge before accept+22 is ignored, one at accept+22 is accepted, and `brd_start` without `brd_valid` is never accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brd_start | input | 1 | Marks rank 0 of a new board |
| brd_valid | input | 1 | Rank beat present on `brd_rank` |
| brd_rank | input | N_FILE*5 | Nine 5-bit squares of one rank |
| cov_valid | output | 1 | Cover row present on `cov_bits` |
| cov_bits | output | N_FILE | Cover bits of one rank, bit f = file f |

## Verification
The assertions assume the feeder never leaves a gap inside a board: once a start is taken, `brd_valid` stays high on the eight edges that follow. The fixed-latency and nine-row checks rely on that assumption. The stimulus drives every board as nine unbroken beats, changing inputs on the falling edge. Extra start pulses are added only on edges where rank data is already present or the block is in its output phase. This keeps the assumption intact while the ignore rule is still exercised.

// File: rtl/rcov_pkg.sv
package rcov_pkg;
  localparam int unsigned SQ_W       = 5;
  localparam int unsigned REACH_ROWS = 5;  // rank offsets -2 .. +2
  localparam int unsigned REACH_COLS = 3;  // file offsets -1 .. +1
  localparam int unsigned REACH_HALF = (REACH_ROWS - 1) / 2;

  typedef logic [SQ_W-1:0] sq_t;
  typedef logic [REACH_ROWS-1:0][REACH_COLS-1:0] reach_t;

  typedef enum logic [3:0] {
    PK_NONE, PK_PAWN, PK_LANCE, PK_KNIGHT, PK_SILVER, PK_GOLD,
    PK_BISHOP, PK_ROOK, PK_KING, PK_TPAWN, PK_TLANCE, PK_TKNIGHT,
    PK_TSILVER, PK_HORSE, PK_DRAGON, PK_SPARE
  } piece_e;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_COMB} phase_e;
endpackage

// File: rtl/rcov_reach.sv
module rcov_reach
  import rcov_pkg::*;
#(
  parameter bit SIDE = 1'b0
) (
  input  sq_t    sq_i,
  output reach_t reach_o
);
  logic [REACH_COLS-1:0] fwd2_row, fwd1_row, side_row, back_row;

  // R3 R4 R5: step patterns in the side's own forward frame; bit c = file offset c-1
  always_comb begin
    fwd2_row = '0;
    fwd1_row = '0;
    side_row = '0;
    back_row = '0;
    case (piece_e'(sq_i[3:0]))
      PK_PAWN, PK_LANCE: fwd1_row = 3'b010;
      PK_KNIGHT:         fwd2_row = 3'b101;
      PK_SILVER: begin
        fwd1_row = 3'b111;
        back_row = 3'b101;
      end
      PK_GOLD, PK_TPAWN, PK_TLANCE, PK_TKNIGHT, PK_TSILVER: begin
        fwd1_row = 3'b111;
        side_row = 3'b101;
        back_row = 3'b010;
      end
      PK_BISHOP: begin
        fwd1_row = 3'b101;
        back_row = 3'b101;
      end
      PK_ROOK: begin
        fwd1_row = 3'b010;
        side_row = 3'b101;
        back_row = 3'b010;
      end
      PK_KING, PK_HORSE, PK_DRAGON: begin
        fwd1_row = 3'b111;
        side_row = 3'b101;
        back_row = 3'b111;
      end
      default: ;
    endcase
    // R2: pieces of the other owner are invisible to this instance
    if (sq_i[SQ_W-1] != SIDE) begin
      fwd2_row = '0;
      fwd1_row = '0;
      side_row = '0;
      back_row = '0;
    end
  end

  // R6: map the forward frame onto absolute rank offsets (row k = offset k-2)
  if (SIDE == 1'b0) begin : g_black
    assign reach_o = {3'b000, back_row, side_row, fwd1_row, fwd2_row};
  end else begin : g_white
    assign reach_o = {fwd2_row, fwd1_row, side_row, back_row, 3'b000};
  end
endmodule

// File: rtl/rcov_spread.sv
module rcov_spread
  import rcov_pkg::*;
#(
  parameter bit          SIDE   = 1'b0,
  parameter int unsigned N_FILE = 9
) (
  input  logic [N_FILE*SQ_W-1:0]             rank_i,
  output logic [REACH_ROWS-1:0][N_FILE-1:0]  spill_o
);
  reach_t reach [N_FILE];
  logic [N_FILE-1:0] foreign;

  for (genvar f = 0; f < N_FILE; f++) begin : g_sq
    rcov_reach #(.SIDE(SIDE)) u_reach (
      .sq_i   (rank_i[f*SQ_W +: SQ_W]),
      .reach_o(reach[f])
    );
    assign foreign[f] = (rank_i[f*SQ_W + SQ_W - 1] != SIDE) || (rank_i[f*SQ_W +: 4] == 4'd0);
  end

  // R7: gather each target file from its own column and both neighbours; edges drop out
  for (genvar t = 0; t < N_FILE; t++) begin : g_col
    for (genvar k = 0; k < REACH_ROWS; k++) begin : g_off
      logic from_lo, from_hi;
      if (t > 0) begin : g_lo
        assign from_lo = reach[t-1][k][2];
      end else begin : g_lo_edge
        assign from_lo = 1'b0;
      end
      if (t < int'(N_FILE) - 1) begin : g_hi
        assign from_hi = reach[t+1][k][0];
      end else begin : g_hi_edge
        assign from_hi = 1'b0;
      end
      assign spill_o[k][t] = from_lo | reach[t][k][1] | from_hi;
    end
  end

  // R2: a rank holding nothing of this side spills nothing
  always_comb begin
    if (&foreign) begin
      p_empty_quiet_r2: assert (spill_o == '0);
    end
  end
endmodule

// File: rtl/rcov_seq.sv
module rcov_seq
  import rcov_pkg::*;
#(
  parameter int unsigned N_RANK = 9,
  parameter int unsigned DRAIN  = 2,
  localparam int unsigned PHASE = N_RANK + DRAIN,
  localparam int unsigned CW    = $clog2(PHASE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          valid_i,
  output logic          take_o,
  output logic          clear_o,
  output logic [CW-1:0] idx_o,
  output logic          emit_o
);
  localparam logic [CW-1:0] LAST  = CW'(PHASE - 1);
  localparam logic [CW-1:0] ROWS  = CW'(N_RANK);

  phase_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          accept;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    accept = (st_q == ST_IDLE) && start_i && valid_i;  // R10: only from idle
    case (st_q)
      ST_IDLE: if (accept) begin
        st_d  = ST_SCAN;
        cnt_d = CW'(1);
      end
      ST_SCAN: if (cnt_q == LAST) begin
        st_d  = ST_COMB;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      ST_COMB: if (cnt_q == LAST) begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign clear_o = accept;
  assign take_o  = accept || ((st_q == ST_SCAN) && (cnt_q < ROWS));
  assign idx_o   = cnt_q;
  assign emit_o  = (st_q == ST_COMB) && (cnt_q < ROWS);

  // R9: a started board arrives without gaps
  p_rank_feed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_SCAN) && (cnt_q < ROWS)) |-> valid_i);
endmodule

// File: rtl/rcov_scan.sv
module rcov_scan
  import rcov_pkg::*;
#(
  parameter bit          SIDE   = 1'b0,
  parameter int unsigned N_FILE = 9,
  parameter int unsigned N_RANK = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     brd_start,
  input  logic                     brd_valid,
  input  logic [N_FILE*SQ_W-1:0]   brd_rank,
  output logic                     cov_valid,
  output logic [N_FILE-1:0]        cov_bits
);
  localparam int unsigned DRAIN    = REACH_HALF;
  localparam int unsigned PHASE    = N_RANK + DRAIN;
  localparam int unsigned CW       = $clog2(PHASE);
  localparam int unsigned AGE_MAX  = 2 * PHASE;
  localparam int unsigned AW       = $clog2(AGE_MAX + 1);
  localparam int unsigned RUNW     = $clog2(N_RANK + 2);

  logic                             take, clear, emit;
  logic [CW-1:0]                    idx;
  logic [REACH_ROWS-1:0][N_FILE-1:0] spill;
  logic [N_FILE-1:0]                pick [N_RANK];
  logic [N_FILE-1:0]                rd_row;
  logic                             val_d;
  logic [N_FILE-1:0]                bits_d;

  rcov_seq #(.N_RANK(N_RANK), .DRAIN(DRAIN)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(brd_start),
    .valid_i(brd_valid),
    .take_o (take),
    .clear_o(clear),
    .idx_o  (idx),
    .emit_o (emit)
  );

  rcov_spread #(.SIDE(SIDE), .N_FILE(N_FILE)) u_spread (
    .rank_i (brd_rank),
    .spill_o(spill)
  );

  // R7: one accumulator row per rank; row q collects spill from ranks q-2 .. q+2
  for (genvar q = 0; q < N_RANK; q++) begin : g_row
    logic [REACH_ROWS-1:0] hit;
    logic [N_FILE-1:0]     add_row, acc_d, acc_q;

    for (genvar k = 0; k < REACH_ROWS; k++) begin : g_off
      localparam int SRC = q - k + int'(REACH_HALF);
      if (SRC >= 0 && SRC < int'(N_RANK)) begin : g_in
        assign hit[k] = take && (idx == CW'(SRC));
      end else begin : g_out
        assign hit[k] = 1'b0;
      end
    end

    always_comb begin
      add_row = '0;
      for (int k = 0; k < REACH_ROWS; k++) begin
        if (hit[k]) add_row = add_row | spill[k];
      end
      acc_d = (clear ? '0 : acc_q) | add_row;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_q <= '0;
      else if (take) acc_q <= acc_d;
    end

    assign pick[q] = (idx == CW'(q)) ? acc_q : '0;
  end

  // R8: stream rows out in rank order, zero when idle
  always_comb begin
    rd_row = '0;
    for (int q = 0; q < N_RANK; q++) rd_row = rd_row | pick[q];
    val_d  = emit;
    bits_d = emit ? rd_row : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cov_valid <= 1'b0;
      cov_bits  <= '0;
    end else begin
      cov_valid <= val_d;
      cov_bits  <= bits_d;
    end
  end

  // checker state: edges since last accept, and length of the current output run
  logic [AW-1:0]   age_q, age_d;
  logic [RUNW-1:0] run_q, run_d;

  always_comb begin
    if (clear)                    age_d = '0;
    else if (age_q == AW'(AGE_MAX)) age_d = age_q;
    else                          age_d = age_q + 1'b1;
    if (!cov_valid)               run_d = '0;
    else if (&run_q)              run_d = run_q;
    else                          run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= AW'(AGE_MAX);
      run_q <= '0;
    end else begin
      age_q <= age_d;
      run_q <= run_d;
    end
  end

  p_fixed_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cov_valid) |-> (age_q == AW'(PHASE)));

  p_accept_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> (age_q >= AW'(AGE_MAX - 1)));

  p_nine_rows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cov_valid) |-> (run_q == RUNW'(N_RANK)));
endmodule

// File: tb/rcov_scan_test.sv
module rcov_scan_test;
  localparam int NF = 9;
  localparam int NR = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            brd_start = 1'b0;
  logic            brd_valid = 1'b0;
  logic [NF*5-1:0] brd_rank = '0;
  logic            cv_b, cv_w;
  logic [NF-1:0]   cb_b, cb_w;

  rcov_scan #(.SIDE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .brd_start(brd_start), .brd_valid(brd_valid),
    .brd_rank(brd_rank), .cov_valid(cv_b), .cov_bits(cb_b));
  rcov_scan #(.SIDE(1'b1)) uut_w (
    .clk(clk), .rst_n(rst_n), .brd_start(brd_start), .brd_valid(brd_valid),
    .brd_rank(brd_rank), .cov_valid(cv_w), .cov_bits(cb_w));

  logic [4:0]    brd [NR][NF];
  logic [NF-1:0] exp_b [NR];
  logic [NF-1:0] exp_w [NR];
  int    e = 0, e_acc = 0, next_ok = 0;
  bit    have_acc = 0;
  int    n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit    done = 0;
  logic [31:0] rng = 32'h1234_5679;

  task automatic check(string what, logic [NF-1:0] act, logic [NF-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, expv);
    end
  endtask

  // reference coverage rule, by relative position (s = steps forward, d = file offset)
  function automatic bit covers(int typ, int s, int d);
    int ad;
    ad = (d < 0) ? -d : d;
    if (typ == 3) return (s == 2) && (ad == 1);
    if (s > 1 || s < -1 || ad > 1 || (s == 0 && d == 0)) return 0;
    case (typ)
      1, 2:              return (s == 1) && (d == 0);
      4:                 return (s == 1) || (s == -1 && ad == 1);
      5, 9, 10, 11, 12:  return (s == 1) || (s == 0) || (s == -1 && d == 0);
      6:                 return (s != 0) && (ad == 1);
      7:                 return (s == 0) || (d == 0);
      8, 13, 14:         return 1;
      default:           return 0;
    endcase
  endfunction

  function automatic logic [NF-1:0] model_row(int side, int tr);
    logic [NF-1:0] row;
    row = '0;
    for (int tf = 0; tf < NF; tf++)
      for (int pr = 0; pr < NR; pr++)
        for (int pf = 0; pf < NF; pf++) begin
          int typ, own, s;
          typ = int'(brd[pr][pf][3:0]);
          own = int'(brd[pr][pf][4]);
          s = (side == 0) ? (pr - tr) : (tr - pr);
          if (typ != 0 && own == side && covers(typ, s, tf - pf)) row[tf] = 1'b1;
        end
    return row;
  endfunction

  function automatic logic [NF*5-1:0] pack(int r);
    logic [NF*5-1:0] v;
    for (int f = 0; f < NF; f++) v[f*5 +: 5] = brd[r][f];
    return v;
  endfunction

  // behavioural model of acceptance and timing
  always @(posedge clk) begin
    if (!rst_n) begin
      e = 0; next_ok = 0; have_acc = 0;
    end else begin
      e++;
      if (brd_start && brd_valid && e >= next_ok) begin
        e_acc = e;
        next_ok = e + 22;
        have_acc = 1;
        for (int r = 0; r < NR; r++) begin
          exp_b[r] = model_row(0, r);
          exp_w[r] = model_row(1, r);
        end
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int k;
      bit ev;
      k = e - e_acc - 11;
      ev = have_acc && k >= 0 && k < NR;
      check("black valid", {8'b0, cv_b}, {8'b0, ev});
      check("black row", cb_b, ev ? exp_b[k] : '0);
      check("white valid", {8'b0, cv_w}, {8'b0, ev});
      check("white row", cb_w, ev ? exp_w[k] : '0);
    end
  end

  task automatic clear_board();
    for (int r = 0; r < NR; r++)
      for (int f = 0; f < NF; f++) brd[r][f] = 5'd0;
  endtask

  task automatic put(int r, int f, int owner, int typ);
    brd[r][f] = {owner[0], typ[3:0]};
  endtask

  // nine beats, then idle until 22 edges after the start; poke adds ignored starts
  task automatic run_board(bit poke);
    for (int r = 0; r < NR; r++) begin
      @(negedge clk);
      brd_start = (r == 0) || (poke && r == 4);
      brd_valid = 1'b1;
      brd_rank  = pack(r);
    end
    for (int t = 9; t <= 21; t++) begin
      @(negedge clk);
      brd_start = poke && (t == 15 || t == 21);
      brd_valid = poke && (t == 15 || t == 21);
      brd_rank  = brd_valid ? pack(t % NR) : '0;
    end
  endtask

  task automatic random_board();
    for (int r = 0; r < NR; r++)
      for (int f = 0; f < NF; f++) begin
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        if (rng[1:0] == 2'd0) brd[r][f] = 5'd0;
        else brd[r][f] = {rng[8], rng[7:4]};
      end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    clear_board();
    // R1: outputs quiet in reset
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("black valid in reset", {8'b0, cv_b}, '0);
    check("black bits in reset", cb_b, '0);
    check("white valid in reset", {8'b0, cv_w}, '0);
    check("white bits in reset", cb_w, '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    cur_req = "R3 R6";
    clear_board();
    put(4, 4, 0, 1); put(6, 1, 0, 2); put(4, 7, 0, 3);
    put(2, 2, 1, 1); put(1, 5, 1, 3); put(5, 6, 1, 2);
    run_board(0);

    cur_req = "R4 R6";
    clear_board();
    put(3, 3, 0, 4); put(6, 6, 0, 5); put(1, 1, 0, 9); put(7, 2, 0, 11);
    put(6, 2, 1, 4); put(2, 7, 1, 12); put(4, 5, 1, 10);
    run_board(0);

    cur_req = "R5 R7";
    clear_board();
    put(2, 2, 0, 6); put(6, 6, 0, 7); put(4, 4, 0, 8);
    put(6, 2, 1, 13); put(2, 7, 1, 14); put(7, 4, 1, 8);
    run_board(0);

    cur_req = "R7";
    clear_board();
    put(0, 0, 0, 3); put(1, 4, 0, 3); put(2, 0, 0, 3); put(8, 8, 0, 8); put(0, 8, 0, 5);
    put(7, 8, 1, 3); put(6, 8, 1, 3); put(0, 0, 1, 8); put(8, 0, 1, 7);
    run_board(0);

    cur_req = "R2";
    for (int r = 0; r < NR; r++)
      for (int f = 0; f < NF; f++)
        put(r, f, (r < 4) ? 0 : 1, (r < 4) ? 15 : 5);
    run_board(0);

    cur_req = "R8 R9";
    clear_board();
    run_board(0);
    for (int r = 0; r < NR; r++)
      for (int f = 0; f < NF; f++) put(r, f, (r + f) % 2, 14);
    run_board(0);

    // R10: start without valid is ignored
    cur_req = "R10";
    @(negedge clk);
    brd_start = 1'b1;
    brd_valid = 1'b0;
    @(negedge clk);
    brd_start = 1'b0;
    repeat (25) @(negedge clk);
    // R10: starts mid-scan, mid-output and on the last busy edge are ignored
    random_board();
    run_board(1);
    random_board();
    run_board(0);

    cur_req = "R3 R4 R5 R6 R7 R8";
    for (int i = 0; i < 12; i++) begin
      random_board();
      run_board(0);
    end

    repeat (30) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule